// File: doc/BRIEF.md
# Private-Cache Line Coherence Controller

This block holds the coherence state of a small set of lines in a private first-level cache within a directory-based multiprocessor. One event enters per cycle through a valid/ready port. An event is either a processor access (load, instruction fetch, store, eviction) or a network message (invalidate, forwarded exclusive or shared request, data, exclusive data, ack, writeback ack). For each accepted event the block updates the addressed line's state. One cycle later it reports the coherence messages to send as a strobe vector, together with completion commands for the processor side.

Each line is in one of five stable states or one of six transient states. The stable states are not-present (NP), invalid (I), shared (S), exclusive (E) and modified (M). The transient states are:
- read pending (IS);
- write pending (IM);
- upgrade pending (SM);
- read pending after a racing invalidate (IS_I);
- writeback pending from modified (M_I);
- writeback pending from exclusive (E_I).

E_I is encoded and handled exactly like M_I. No transition enters it, because a clean exclusive eviction also goes to M_I. Transitions: miss (NP/I to IS or IM), upgrade (S to SM), silent store (E to M), fill (IS to S or E; IS_I to I or E), ack collection (IM to SM to M, or IM to M), eviction (E/M to M_I; NP/I/S to NP), writeback completion (M_I to I), forwarded read (E/M to S), forwarded exclusive or invalidate (to I), and invalidate race (IS to IS_I; SM to IM).

A signed per-line counter collects invalidation acks. Data and ack messages carry a signed count that is subtracted from the counter. The write completes when the counter reaches zero. Data storage, the network and the directory are outside the block; data movement appears only as command bits.

Top module: `l1coh_ctrl`

## Requirements
- R1: After reset every line is NP with permission none, evt_ready is high and out_valid is low.
- R2: From NP or I, a load (code 0) sends GETS and enters IS, an instruction fetch (code 1) sends GET_INSTR and enters IS, and a store (code 2) sends GETX and enters IM. Each of these clears the line's ack counter.
- R3: A load or instruction fetch in S, E or M raises out_load_done with no message. A store in E raises out_store_done and moves to M with no message, and a store in M raises out_store_done and stays in M.
- R4: A store in S sends UPGRADE, clears the ack counter and enters SM.
- R5: A processor event (codes 0 to 3) whose line is in a transient state sees evt_ready low and changes nothing. Network events (codes 4 to 11) are always accepted.
- R6: In IS, data (code 8) raises out_load_done, sends UNBLOCK and enters S. Exclusive data (code 9) in IS or IS_I raises out_load_done, sends EXCLUSIVE_UNBLOCK and enters E.
- R7: An invalidate (code 4) in IS or IS_I is acked and leaves IS_I. Data in IS_I then raises out_load_done, sends UNBLOCK and leaves the line I.
- R8: In IM, data subtracts its count from the ack counter. If the result is zero, the block sends EXCLUSIVE_UNBLOCK, raises out_store_done and enters M; otherwise it enters SM. An ack (code 10) in IM or SM subtracts its count. In SM a zero result completes the same way as data in IM; in IM the state does not change.
- R9: An eviction (code 3) moves NP, I or S to NP silently. In E or M it sends PUTX and enters M_I. A writeback ack (code 11) in M_I enters I.
- R10: In M_I the following responses are sent with out_from_buf high, and each of them ends in I:
  - a forwarded exclusive request (code 5) sends data to the requester;
  - a forwarded shared request or instruction request (codes 6, 7) sends data to the requester and to L2;
  - an invalidate sends data to L2.
- R11: In E or M, a forwarded shared or instruction request sends data to the requester and to L2 and enters S, while a forwarded exclusive request sends data to the requester and enters I. An invalidate is handled by state:
  - in NP, I, S or E it is acked (S and E go to I);
  - in M it sends data to L2 and goes to I;
  - in IM or SM it is acked and goes to IM.
  Any other network event, and any code above 11, is accepted with no effect.
- R12: line_perm holds 2 bits per line, with line n at bits 2n+1:2n. The encoding is 0 for NP or I, 1 for S or E, 2 for M and 3 for any transient state.
- R13: The outputs of an accepted event appear on the clock edge after acceptance, and out_valid is low otherwise. out_msg bits, from bit 0 upward, are:
  - bit 0 GETS, bit 1 GET_INSTR, bit 2 GETX, bit 3 UPGRADE, bit 4 PUTX;
  - bit 5 data to requester, bit 6 data to L2, bit 7 invalidate ack;
  - bit 8 UNBLOCK, bit 9 EXCLUSIVE_UNBLOCK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 1 | Event offered |
| evt_ready | output | 1 | Event can be accepted this cycle |
| evt_kind | input | 4 | Event code |
| evt_line | input | LINE_W | Line index |
| evt_count | input | CNT_W | Signed ack count carried by data and ack events |
| out_valid | output | 1 | Result of an accepted event |
| out_line | output | LINE_W | Line the result refers to |
| out_msg | output | 10 | Message strobes |
| out_load_done | output | 1 | Load or fetch completed |
| out_store_done | output | 1 | Store completed |
| out_from_buf | output | 1 | Data is sourced from the eviction buffer |
| line_perm | output | 2*NUM_LINES | Per-line access permission |

## Verification
Two functions coincide in a single step in this block. The first is answering a forwarded request while a writeback is pending: the data answer and the retirement of the eviction buffer happen together. The second is the arrival of the last ack, which in the same step completes the store and sends the exclusive unblock. The bench evicts a modified line and then forwards a shared request, an exclusive request or an invalidate before any writeback ack. It also sends acks to a write-pending line before its data arrives, so that the counter goes negative. The reference model expects the message bits, the buffer flag, the completion bit and the new permission all on the same output cycle.

// File: rtl/l1coh_pkg.sv
package l1coh_pkg;

    typedef enum logic [3:0] {
        ST_NP,
        ST_I,
        ST_S,
        ST_E,
        ST_M,
        ST_RD_PEND,    // IS
        ST_WR_PEND,    // IM
        ST_UPG_PEND,   // SM
        ST_RD_KILLED,  // IS_I
        ST_WB_PEND_M,  // M_I
        ST_WB_PEND_E   // E_I
    } line_state_e;

    typedef enum logic [3:0] {
        EV_LOAD      = 4'd0,
        EV_IFETCH    = 4'd1,
        EV_STORE     = 4'd2,
        EV_EVICT     = 4'd3,
        EV_INV       = 4'd4,
        EV_FWD_EXCL  = 4'd5,
        EV_FWD_SHR   = 4'd6,
        EV_FWD_INSTR = 4'd7,
        EV_DATA      = 4'd8,
        EV_DATA_EXCL = 4'd9,
        EV_ACK       = 4'd10,
        EV_WB_ACK    = 4'd11
    } evt_e;

    typedef enum logic [1:0] {
        PERM_NONE = 2'd0,
        PERM_RO   = 2'd1,
        PERM_RW   = 2'd2,
        PERM_BUSY = 2'd3
    } perm_e;

    localparam int MSG_W        = 10;
    localparam int MSG_GETS     = 0;
    localparam int MSG_GETI     = 1;
    localparam int MSG_GETX     = 2;
    localparam int MSG_UPG      = 3;
    localparam int MSG_PUTX     = 4;
    localparam int MSG_D_REQ    = 5;
    localparam int MSG_D_L2     = 6;
    localparam int MSG_INV_ACK  = 7;
    localparam int MSG_UNB      = 8;
    localparam int MSG_UNB_EXCL = 9;

    function automatic logic is_transient(line_state_e s);
        return (s == ST_RD_PEND) || (s == ST_WR_PEND) || (s == ST_UPG_PEND) ||
               (s == ST_RD_KILLED) || (s == ST_WB_PEND_M) || (s == ST_WB_PEND_E);
    endfunction

    function automatic logic is_proc(evt_e e);
        return (e == EV_LOAD) || (e == EV_IFETCH) || (e == EV_STORE) || (e == EV_EVICT);
    endfunction

    function automatic perm_e perm_of(line_state_e s);
        perm_e p;
        unique case (s)
            ST_NP, ST_I: p = PERM_NONE;
            ST_S, ST_E:  p = PERM_RO;
            ST_M:        p = PERM_RW;
            default:     p = PERM_BUSY;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/l1coh_fsm.sv
module l1coh_fsm
    import l1coh_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  line_state_e             cur,
    input  evt_e                    ev,
    input  logic signed [CNT_W-1:0] pend,
    input  logic signed [CNT_W-1:0] cnt,
    output line_state_e             nxt,
    output logic signed [CNT_W-1:0] nxt_pend,
    output logic [MSG_W-1:0]        msg,
    output logic                    load_done,
    output logic                    store_done,
    output logic                    from_buf,
    output logic                    stall
);

    logic signed [CNT_W-1:0] rem;

    always_comb begin
        nxt        = cur;
        nxt_pend   = pend;
        msg        = '0;
        load_done  = 1'b0;
        store_done = 1'b0;
        from_buf   = 1'b0;
        rem        = pend - cnt;
        stall      = is_proc(ev) && is_transient(cur);

        unique case (cur)
            ST_NP, ST_I: begin
                unique case (ev)
                    EV_LOAD:   begin msg[MSG_GETS] = 1'b1; nxt = ST_RD_PEND; nxt_pend = '0; end
                    EV_IFETCH: begin msg[MSG_GETI] = 1'b1; nxt = ST_RD_PEND; nxt_pend = '0; end
                    EV_STORE:  begin msg[MSG_GETX] = 1'b1; nxt = ST_WR_PEND; nxt_pend = '0; end
                    EV_EVICT:  nxt = ST_NP;
                    EV_INV:    msg[MSG_INV_ACK] = 1'b1;
                    default:   ;
                endcase
            end
            ST_S: begin
                unique case (ev)
                    EV_LOAD, EV_IFETCH: load_done = 1'b1;
                    EV_STORE: begin msg[MSG_UPG] = 1'b1; nxt = ST_UPG_PEND; nxt_pend = '0; end
                    EV_EVICT: nxt = ST_NP;
                    EV_INV:   begin msg[MSG_INV_ACK] = 1'b1; nxt = ST_I; end
                    default:  ;
                endcase
            end
            ST_E, ST_M: begin
                unique case (ev)
                    EV_LOAD, EV_IFETCH: load_done = 1'b1;
                    EV_STORE: begin store_done = 1'b1; nxt = ST_M; end
                    EV_EVICT: begin msg[MSG_PUTX] = 1'b1; nxt = ST_WB_PEND_M; end
                    EV_INV: begin
                        if (cur == ST_M) msg[MSG_D_L2] = 1'b1;
                        else             msg[MSG_INV_ACK] = 1'b1;
                        nxt = ST_I;
                    end
                    EV_FWD_EXCL: begin msg[MSG_D_REQ] = 1'b1; nxt = ST_I; end
                    EV_FWD_SHR, EV_FWD_INSTR: begin
                        msg[MSG_D_REQ] = 1'b1;
                        msg[MSG_D_L2]  = 1'b1;
                        nxt = ST_S;
                    end
                    default: ;
                endcase
            end
            ST_RD_PEND, ST_RD_KILLED: begin
                unique case (ev)
                    EV_INV: begin msg[MSG_INV_ACK] = 1'b1; nxt = ST_RD_KILLED; end
                    EV_DATA: begin
                        msg[MSG_UNB] = 1'b1;
                        load_done    = 1'b1;
                        nxt = (cur == ST_RD_PEND) ? ST_S : ST_I;
                    end
                    EV_DATA_EXCL: begin msg[MSG_UNB_EXCL] = 1'b1; load_done = 1'b1; nxt = ST_E; end
                    default: ;
                endcase
            end
            ST_WR_PEND: begin
                unique case (ev)
                    EV_INV: msg[MSG_INV_ACK] = 1'b1;
                    EV_DATA: begin
                        nxt_pend = rem;
                        if (rem == '0) begin
                            msg[MSG_UNB_EXCL] = 1'b1;
                            store_done = 1'b1;
                            nxt = ST_M;
                        end else begin
                            nxt = ST_UPG_PEND;
                        end
                    end
                    EV_ACK:  nxt_pend = rem;
                    default: ;
                endcase
            end
            ST_UPG_PEND: begin
                unique case (ev)
                    EV_INV: begin msg[MSG_INV_ACK] = 1'b1; nxt = ST_WR_PEND; end
                    EV_ACK: begin
                        nxt_pend = rem;
                        if (rem == '0) begin
                            msg[MSG_UNB_EXCL] = 1'b1;
                            store_done = 1'b1;
                            nxt = ST_M;
                        end
                    end
                    default: ;
                endcase
            end
            ST_WB_PEND_M, ST_WB_PEND_E: begin
                unique case (ev)
                    EV_WB_ACK: nxt = ST_I;
                    EV_FWD_EXCL: begin msg[MSG_D_REQ] = 1'b1; from_buf = 1'b1; nxt = ST_I; end
                    EV_FWD_SHR, EV_FWD_INSTR: begin
                        msg[MSG_D_REQ] = 1'b1;
                        msg[MSG_D_L2]  = 1'b1;
                        from_buf = 1'b1;
                        nxt = ST_I;
                    end
                    EV_INV: begin msg[MSG_D_L2] = 1'b1; from_buf = 1'b1; nxt = ST_I; end
                    default: ;
                endcase
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/l1coh_line_bank.sv
module l1coh_line_bank
    import l1coh_pkg::*;
#(
    parameter  int NUM_LINES = 4,
    parameter  int CNT_W     = 6,
    localparam int LINE_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [LINE_W-1:0]       wr_line,
    input  line_state_e             wr_state,
    input  logic signed [CNT_W-1:0] wr_pend,
    output line_state_e             st_o   [NUM_LINES],
    output logic signed [CNT_W-1:0] pend_o [NUM_LINES],
    output logic [2*NUM_LINES-1:0]  perm_o
);

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        line_state_e             st_q;
        logic signed [CNT_W-1:0] pend_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st_q   <= ST_NP;
                pend_q <= '0;
            end else if (wr_en && (wr_line == LINE_W'(g))) begin
                st_q   <= wr_state;
                pend_q <= wr_pend;
            end
        end

        assign st_o[g]          = st_q;
        assign pend_o[g]        = pend_q;
        assign perm_o[2*g +: 2] = perm_of(st_q);
    end

endmodule

// File: rtl/l1coh_ctrl.sv
module l1coh_ctrl
    import l1coh_pkg::*;
#(
    parameter  int NUM_LINES = 4,
    parameter  int CNT_W     = 6,
    localparam int LINE_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   evt_valid,
    output logic                   evt_ready,
    input  logic [3:0]             evt_kind,
    input  logic [LINE_W-1:0]      evt_line,
    input  logic [CNT_W-1:0]       evt_count,
    output logic                   out_valid,
    output logic [LINE_W-1:0]      out_line,
    output logic [9:0]             out_msg,
    output logic                   out_load_done,
    output logic                   out_store_done,
    output logic                   out_from_buf,
    output logic [2*NUM_LINES-1:0] line_perm
);

    evt_e                    ev;
    line_state_e             st_arr   [NUM_LINES];
    logic signed [CNT_W-1:0] pend_arr [NUM_LINES];
    line_state_e             cur;
    logic signed [CNT_W-1:0] cur_pend;
    line_state_e             nxt;
    logic signed [CNT_W-1:0] nxt_pend;
    logic [MSG_W-1:0]        msg;
    logic                    ld_done;
    logic                    st_done;
    logic                    fbuf;
    logic                    stall;
    logic                    accept;

    assign ev        = evt_e'(evt_kind);
    assign cur       = st_arr[evt_line];
    assign cur_pend  = pend_arr[evt_line];
    assign evt_ready = !stall;
    assign accept    = evt_valid && evt_ready;

    l1coh_fsm #(.CNT_W(CNT_W)) u_fsm (
        .cur        (cur),
        .ev         (ev),
        .pend       (cur_pend),
        .cnt        ($signed(evt_count)),
        .nxt        (nxt),
        .nxt_pend   (nxt_pend),
        .msg        (msg),
        .load_done  (ld_done),
        .store_done (st_done),
        .from_buf   (fbuf),
        .stall      (stall)
    );

    l1coh_line_bank #(.NUM_LINES(NUM_LINES), .CNT_W(CNT_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (accept),
        .wr_line  (evt_line),
        .wr_state (nxt),
        .wr_pend  (nxt_pend),
        .st_o     (st_arr),
        .pend_o   (pend_arr),
        .perm_o   (line_perm)
    );

    always_ff @(posedge clk) begin
        if (!rst_n || !accept) begin
            out_valid      <= 1'b0;
            out_line       <= '0;
            out_msg        <= '0;
            out_load_done  <= 1'b0;
            out_store_done <= 1'b0;
            out_from_buf   <= 1'b0;
        end else begin
            out_valid      <= 1'b1;
            out_line       <= evt_line;
            out_msg        <= msg;
            out_load_done  <= ld_done;
            out_store_done <= st_done;
            out_from_buf   <= fbuf;
        end
    end

    AST_OUT_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(evt_valid && evt_ready));                        // R13
    AST_IDLE_KEEPS_PERM: assert property (@(posedge clk) disable iff (!rst_n)
        !(evt_valid && evt_ready) |=> $stable(line_perm));                   // R5
    AST_ONE_UNBLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(out_msg[MSG_UNB_EXCL:MSG_UNB]));                            // R6
    AST_STORE_OWNS: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_store_done) |-> (line_perm[2*out_line +: 2] == PERM_RW)); // R8
    AST_BUF_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_from_buf) |-> (line_perm[2*out_line +: 2] == PERM_NONE)); // R10
    AST_REQ_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && |out_msg[MSG_UPG:MSG_GETS]) |-> (line_perm[2*out_line +: 2] == PERM_BUSY)); // R2

endmodule

// File: tb/l1coh_ctrl_tb.sv
module l1coh_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NL = 4;
    localparam int CW = 6;

    // model state codes
    localparam int S_NP = 0, S_I = 1, S_S = 2, S_E = 3, S_M = 4;
    localparam int S_IS = 5, S_IM = 6, S_SM = 7, S_ISI = 8, S_MI = 9;
    // event codes
    localparam int K_LD = 0, K_IF = 1, K_ST = 2, K_EV = 3, K_INV = 4, K_FX = 5;
    localparam int K_FS = 6, K_FI = 7, K_DAT = 8, K_DX = 9, K_ACK = 10, K_WB = 11;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          evt_valid = 1'b0;
    logic          evt_ready;
    logic [3:0]    evt_kind = '0;
    logic [1:0]    evt_line = '0;
    logic [CW-1:0] evt_count = '0;
    logic          out_valid;
    logic [1:0]    out_line;
    logic [9:0]    out_msg;
    logic          out_load_done, out_store_done, out_from_buf;
    logic [2*NL-1:0] line_perm;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int m_st [NL];
    int m_p  [NL];

    always #(CLK_PERIOD/2) clk = ~clk;

    l1coh_ctrl #(.NUM_LINES(NL), .CNT_W(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_ready(evt_ready),
        .evt_kind(evt_kind), .evt_line(evt_line), .evt_count(evt_count),
        .out_valid(out_valid), .out_line(out_line), .out_msg(out_msg),
        .out_load_done(out_load_done), .out_store_done(out_store_done),
        .out_from_buf(out_from_buf), .line_perm(line_perm)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            fails++;
            $display("FAIL watchdog: run did not end, actual %0d cycles expected < 20000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic bit busy(int s);
        return s >= S_IS;
    endfunction

    function automatic int perm_exp(int s);
        if (s == S_NP || s == S_I) return 0;
        if (s == S_S || s == S_E) return 1;
        if (s == S_M) return 2;
        return 3;
    endfunction

    task automatic check_perms(input string tag);
        for (int i = 0; i < NL; i++)
            chk(tag, $sformatf("perm line %0d (R12)", i), int'(line_perm[2*i +: 2]), perm_exp(m_st[i]));
    endtask

    // behavioural reference of one accepted event
    task automatic ref_step(input int k, input int ln, input int c,
                            output int msg, output int ld, output int sd, output int fb);
        int s;
        s = m_st[ln];
        msg = 0; ld = 0; sd = 0; fb = 0;
        if (k == K_LD || k == K_IF) begin
            if (s == S_NP || s == S_I) begin
                msg = (k == K_LD) ? 1 : 2; m_st[ln] = S_IS; m_p[ln] = 0;
            end else if (s == S_S || s == S_E || s == S_M) ld = 1;
        end else if (k == K_ST) begin
            if (s == S_NP || s == S_I) begin msg = 4; m_st[ln] = S_IM; m_p[ln] = 0; end
            else if (s == S_S) begin msg = 8; m_st[ln] = S_SM; m_p[ln] = 0; end
            else if (s == S_E || s == S_M) begin sd = 1; m_st[ln] = S_M; end
        end else if (k == K_EV) begin
            if (s == S_NP || s == S_I || s == S_S) m_st[ln] = S_NP;
            else if (s == S_E || s == S_M) begin msg = 16; m_st[ln] = S_MI; end
        end else if (k == K_INV) begin
            if (s == S_NP || s == S_I) msg = 128;
            else if (s == S_S || s == S_E) begin msg = 128; m_st[ln] = S_I; end
            else if (s == S_M) begin msg = 64; m_st[ln] = S_I; end
            else if (s == S_IS || s == S_ISI) begin msg = 128; m_st[ln] = S_ISI; end
            else if (s == S_IM || s == S_SM) begin msg = 128; m_st[ln] = S_IM; end
            else if (s == S_MI) begin msg = 64; fb = 1; m_st[ln] = S_I; end
        end else if (k == K_FX) begin
            if (s == S_E || s == S_M) begin msg = 32; m_st[ln] = S_I; end
            else if (s == S_MI) begin msg = 32; fb = 1; m_st[ln] = S_I; end
        end else if (k == K_FS || k == K_FI) begin
            if (s == S_E || s == S_M) begin msg = 96; m_st[ln] = S_S; end
            else if (s == S_MI) begin msg = 96; fb = 1; m_st[ln] = S_I; end
        end else if (k == K_DAT) begin
            if (s == S_IS) begin msg = 256; ld = 1; m_st[ln] = S_S; end
            else if (s == S_ISI) begin msg = 256; ld = 1; m_st[ln] = S_I; end
            else if (s == S_IM) begin
                m_p[ln] -= c;
                if (m_p[ln] == 0) begin msg = 512; sd = 1; m_st[ln] = S_M; end
                else m_st[ln] = S_SM;
            end
        end else if (k == K_DX) begin
            if (s == S_IS || s == S_ISI) begin msg = 512; ld = 1; m_st[ln] = S_E; end
        end else if (k == K_ACK) begin
            if (s == S_IM) m_p[ln] -= c;
            else if (s == S_SM) begin
                m_p[ln] -= c;
                if (m_p[ln] == 0) begin msg = 512; sd = 1; m_st[ln] = S_M; end
            end
        end else if (k == K_WB) begin
            if (s == S_MI) m_st[ln] = S_I;
        end
    endtask

    task automatic step(input int k, input int ln, input int c, input string tag);
        bit acc;
        int msg, ld, sd, fb;
        evt_valid = 1'b1;
        evt_kind  = 4'(k);
        evt_line  = 2'(ln);
        evt_count = CW'(c);
        #1;
        acc = !(k <= K_EV && busy(m_st[ln]));
        chk(tag, "evt_ready", int'(evt_ready), int'(acc));
        msg = 0; ld = 0; sd = 0; fb = 0;
        if (acc) ref_step(k, ln, c, msg, ld, sd, fb);
        @(negedge clk);
        evt_valid = 1'b0;
        chk(tag, "out_valid (R13)", int'(out_valid), int'(acc));
        if (acc) begin
            chk(tag, "out_line", int'(out_line), ln);
            chk(tag, "out_msg", int'(out_msg), msg);
            chk(tag, "out_load_done", int'(out_load_done), ld);
            chk(tag, "out_store_done", int'(out_store_done), sd);
            chk(tag, "out_from_buf", int'(out_from_buf), fb);
        end
        check_perms(tag);
    endtask

    task automatic idle(input string tag);
        evt_valid = 1'b0;
        @(negedge clk);
        chk(tag, "out_valid idle", int'(out_valid), 0);
        check_perms(tag);
    endtask

    initial begin
        for (int i = 0; i < NL; i++) begin m_st[i] = S_NP; m_p[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "evt_ready", int'(evt_ready), 1);
        chk("R1", "out_valid", int'(out_valid), 0);
        check_perms("R1");

        // line 0: read miss raced by invalidate
        step(K_LD,  0, 0, "R2");
        step(K_LD,  0, 0, "R5");
        step(K_ST,  0, 0, "R5");
        step(K_INV, 0, 0, "R7");
        step(K_INV, 0, 0, "R7");
        step(K_DAT, 0, 0, "R7");

        // line 1: fetch, exclusive fill, silent store, downgrade, upgrade
        step(K_IF,  1, 0, "R2");
        step(K_DX,  1, 0, "R6");
        step(K_LD,  1, 0, "R3");
        step(K_ST,  1, 0, "R3");
        step(K_ST,  1, 0, "R3");
        step(K_FS,  1, 0, "R11");
        step(K_IF,  1, 0, "R3");
        step(K_ST,  1, 0, "R4");
        step(K_EV,  1, 0, "R5");
        step(K_ACK, 1, -2, "R8");
        step(K_ACK, 1, 1, "R8");
        step(K_ACK, 1, 1, "R8");
        idle("R13");

        // line 2: acks before data, then writeback raced by forwarded read
        step(K_ST,  2, 0, "R2");
        step(K_ACK, 2, 1, "R8");
        step(K_DAT, 2, -2, "R8");
        step(K_ACK, 2, 1, "R8");
        step(K_EV,  2, 0, "R9");
        step(K_LD,  2, 0, "R5");
        step(K_INV, 3, 0, "R11");
        step(K_FS,  2, 0, "R10");

        // line 3: shared fill, invalidate, direct exclusive fill, forwarded exclusive
        step(K_LD,  3, 0, "R2");
        step(K_DAT, 3, 0, "R6");
        step(K_WB,  3, 0, "R11");
        step(K_FX,  3, 0, "R11");
        step(K_INV, 3, 0, "R11");
        step(K_ST,  3, 0, "R2");
        step(K_DAT, 3, 0, "R8");
        step(K_FX,  3, 0, "R11");
        step(K_LD,  3, 0, "R2");
        step(K_DX,  3, 0, "R6");
        step(K_EV,  3, 0, "R9");
        step(K_WB,  3, 0, "R9");
        step(K_EV,  3, 0, "R9");
        step(4'd14, 3, 0, "R11");

        // line 0: write miss with invalidate, modified invalidate, shared eviction
        step(K_ST,  0, 0, "R2");
        step(K_INV, 0, 0, "R11");
        step(K_DAT, 0, 0, "R8");
        step(K_INV, 0, 0, "R11");
        step(K_LD,  0, 0, "R2");
        step(K_DAT, 0, 0, "R6");
        step(K_EV,  0, 0, "R9");

        // writeback pending answered by invalidate and by forwarded exclusive
        step(K_EV,  1, 0, "R9");
        step(K_INV, 1, 0, "R10");
        step(K_ST,  2, 0, "R2");
        step(K_DAT, 2, 0, "R8");
        step(K_EV,  2, 0, "R9");
        step(K_FX,  2, 0, "R10");
        step(K_LD,  1, 0, "R2");
        step(K_DX,  1, 0, "R6");
        step(K_EV,  1, 0, "R9");
        step(K_FI,  1, 0, "R10");
        idle("R13");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule